// File: doc/BRIEF.md
# Word Reservation Monitor for Exclusive Accesses

This block sits between one processor's load/store path and a local word memory. It lets software update a word atomically through a paired read-then-conditional-write sequence, with no bus locking. A reserving load returns the stored word and opens a reservation on that word's address. A later conditional store to the same word writes only while the reservation is still held. It reports a pass or fail flag instead of a plain acknowledge, and software retries on a fail.

The monitor holds a single reservation, made of a held flag and a word-address tag. Plain loads and plain stores go straight to the memory and leave the reservation alone. The reservation is dropped by every conditional store, whether it passes or fails. It is also dropped by an explicit clear request and by an exception-entry pulse. Tracking covers one processor only. The block never stalls a request: every request completes in the cycle it is presented, and any response appears on the next cycle.

Top module: `excl_access_unit`

## Requirements
- R1: After reset the reservation is not held, and `rsp_valid`, `rsp_fail`, `rsp_rdata` and `mem_we` are all 0.
- R2: The value of `req_op` selects the request: 0 idle, 1 plain load, 2 plain store, 3 reserving load, 4 conditional store, 5 clear reservation. Values 6 and 7 act as idle. Loads (1 and 3) and conditional stores (4) raise `rsp_valid` on the cycle after the request. Idle and clear requests do not raise it.
- R3: A plain or reserving load returns the word stored at `req_addr` on `rsp_rdata` in the cycle after the request.
- R4: A plain store raises `mem_we` during its request cycle, and the word is written at the following clock edge.
- R5: A reserving load makes the reservation held and sets its tag to `req_addr`. A conditional store to the tagged address while the reservation is held raises `mem_we`, writes the word, and returns `rsp_fail` = 0.
- R6: A conditional store while no reservation is held, including one issued right after reset, keeps `mem_we` low, leaves memory unchanged, and returns `rsp_fail` = 1.
- R7: A conditional store to an address other than the tag fails (`rsp_fail` = 1, no write), even while the reservation is held.
- R8: Every conditional store drops the reservation, whether it passed or failed.
- R9: A clear request (op 5) drops the reservation.
- R10: A pulse on `exc_entry` drops the reservation and takes precedence over any request in the same cycle. A conditional store in that cycle fails without writing, and a reserving load in that cycle still returns data but leaves no reservation.
- R11: A second reserving load moves the tag to its own address, so only that address can pass the next conditional store. Plain loads and plain stores never change the reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Request code (see R2) |
| req_addr | input | AW (8) | Word address of the request |
| req_wdata | input | DW (32) | Store data |
| exc_entry | input | 1 | Exception-entry pulse, drops the reservation |
| mem_we | output | 1 | Memory write strobe for the current request |
| rsp_valid | output | 1 | Response present for the previous request |
| rsp_rdata | output | DW (32) | Load data for the previous request, else 0 |
| rsp_fail | output | 1 | Conditional-store status: 1 = not written |

## Verification
A wrong held flag shows up at the next conditional store. That store either writes when it should not (`mem_we` high in its own cycle, followed by a later load returning the new word) or reports a fail for a valid sequence one cycle after the request. A corrupted tag shows up only when a conditional store targets the old or the new address, so the directed sequences pair every reservation change with a conditional store on both the replaced address and the current one. A clear, exception or store that fails to drop the reservation is exposed by a second conditional store that unexpectedly passes.

// File: rtl/excl_pkg.sv
package excl_pkg;

    localparam logic [2:0] OP_IDLE  = 3'd0;
    localparam logic [2:0] OP_LOAD  = 3'd1;
    localparam logic [2:0] OP_STORE = 3'd2;
    localparam logic [2:0] OP_LDX   = 3'd3;
    localparam logic [2:0] OP_STX   = 3'd4;
    localparam logic [2:0] OP_CLRX  = 3'd5;

    // decoded actions for one request
    typedef struct packed {
        logic rd;     // any load
        logic wr;     // plain store
        logic ldx;    // reserving load
        logic stx;    // conditional store
        logic clr;    // clear request
        logic rsp;    // produces a response
    } act_t;

endpackage

// File: rtl/excl_op_decode.sv
module excl_op_decode
    import excl_pkg::*;
(
    input  logic [2:0] op,
    output act_t       act
);

    always_comb begin
        act = '0;
        unique case (op)
            OP_LOAD:  begin act.rd  = 1'b1; act.rsp = 1'b1; end
            OP_STORE: begin act.wr  = 1'b1; end
            OP_LDX:   begin act.rd  = 1'b1; act.ldx = 1'b1; act.rsp = 1'b1; end
            OP_STX:   begin act.stx = 1'b1; act.rsp = 1'b1; end
            OP_CLRX:  begin act.clr = 1'b1; end
            default:  act = '0;
        endcase
    end

endmodule

// File: rtl/excl_resv_tracker.sv
module excl_resv_tracker
    import excl_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_t          act,
    input  logic [AW-1:0] addr,
    input  logic          exc_entry,
    output logic          stx_pass,
    output logic          held_q,
    output logic [AW-1:0] tag_q
);

    typedef struct packed {
        logic          held;
        logic [AW-1:0] tag;
    } resv_t;

    resv_t resv_d, resv_q;

    always_comb begin
        resv_d   = resv_q;
        stx_pass = act.stx && resv_q.held && (resv_q.tag == addr) && !exc_entry;
        if (exc_entry) begin
            resv_d.held = 1'b0;
        end else if (act.ldx) begin
            resv_d.held = 1'b1;
            resv_d.tag  = addr;
        end else if (act.stx || act.clr) begin
            resv_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resv_q <= '0;
        else        resv_q <= resv_d;
    end

    assign held_q = resv_q.held;
    assign tag_q  = resv_q.tag;

endmodule

// File: rtl/excl_word_store.sv
module excl_word_store #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d;

    always_comb begin
        rdata_d = re ? mem[addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

endmodule

// File: rtl/excl_access_unit.sv
module excl_access_unit
    import excl_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          exc_entry,
    output logic          mem_we,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_fail
);

    typedef struct packed {
        logic valid;
        logic fail;
    } rsp_t;

    act_t          act;
    logic          stx_pass;
    logic          resv_held;
    logic [AW-1:0] resv_tag;
    rsp_t          rsp_d, rsp_q;

    excl_op_decode u_dec (
        .op  (req_op),
        .act (act)
    );

    excl_resv_tracker #(.AW(AW)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .addr      (req_addr),
        .exc_entry (exc_entry),
        .stx_pass  (stx_pass),
        .held_q    (resv_held),
        .tag_q     (resv_tag)
    );

    excl_word_store #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .re      (act.rd),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .rdata_q (rsp_rdata)
    );

    always_comb begin
        mem_we      = act.wr || stx_pass;
        rsp_d.valid = act.rsp;
        rsp_d.fail  = act.stx && !stx_pass;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fail  = rsp_q.fail;

endmodule

// File: rtl/excl_access_chk.sv
module excl_access_chk
    import excl_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic          exc_entry,
    input logic          mem_we,
    input logic          rsp_valid,
    input logic          rsp_fail,
    input logic          resv_held,
    input logic [AW-1:0] resv_tag
);

    // R4: a plain store always strobes the memory
    a_r4_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STORE) |-> mem_we);

    // R2: responses follow loads and conditional stores only
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_LOAD || req_op == OP_LDX || req_op == OP_STX) |=> rsp_valid);

    a_r2_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_op == OP_LOAD || req_op == OP_LDX || req_op == OP_STX) |=> !rsp_valid);

    // R5: fail flag is the inverse of the write strobe of the previous conditional store
    a_r5_status_matches_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STX) |=> (rsp_fail == !$past(mem_we)));

    // R6: no reservation means no write
    a_r6_open_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STX && !resv_held) |-> !mem_we);

    // R7: tag mismatch means no write
    a_r7_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STX && resv_tag != req_addr) |-> !mem_we);

    // R8, R9: conditional store and clear both drop the reservation
    a_r8_stx_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STX) |=> !resv_held);

    a_r9_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_CLRX) |=> !resv_held);

    // R10: exception entry wins over every request
    a_r10_exc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> !resv_held);

    a_r10_exc_blocks_stx: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_entry && req_op == OP_STX) |-> !mem_we);

    // R11: plain traffic leaves the reservation untouched
    a_r11_plain_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_op == OP_LOAD || req_op == OP_STORE) && !exc_entry)
        |=> ($stable(resv_held) && $stable(resv_tag)));

    // write strobe only for stores
    a_r4_we_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_op == OP_STORE || req_op == OP_STX));

endmodule

bind excl_access_unit excl_access_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .exc_entry (exc_entry),
    .mem_we    (mem_we),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail),
    .resv_held (resv_held),
    .resv_tag  (resv_tag)
);

// File: tb/tb_excl_access_unit.sv
module tb_excl_access_unit;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          exc_entry = 1'b0;
    logic          mem_we;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_fail;

    int checks = 0;
    int failures = 0;

    // response captures
    logic          s_we, s_rv, s_fl;
    logic [DW-1:0] s_rd;

    excl_access_unit #(.AW(AW), .DW(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .exc_entry (exc_entry),
        .mem_we    (mem_we),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_fail  (rsp_fail)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request: drive at a falling edge, catch the strobe, then the response
    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic exc);
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = d; exc_entry = exc;
        #1 s_we = mem_we;
        @(negedge clk);
        s_rv = rsp_valid; s_rd = rsp_rdata; s_fl = rsp_fail;
        req_op = 3'd0; exc_entry = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 rsp_fail", {31'd0, rsp_fail}, 32'd0);
        chk("R1 rsp_rdata", rsp_rdata, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        do_op(3'd2, 8'h20, 32'h1111_0000, 1'b0);
        do_op(3'd4, 8'h20, 32'hBAD0_0001, 1'b0);
        chk("R6 stx after reset we", {31'd0, s_we}, 32'd0);
        chk("R6 stx after reset fail", {31'd0, s_fl}, 32'd1);
        do_op(3'd1, 8'h20, 32'd0, 1'b0);
        chk("R6 memory unchanged", s_rd, 32'h1111_0000);
    endtask

    task automatic t_basic;
        do_op(3'd2, 8'h10, 32'hA5A5_0010, 1'b0);
        chk("R4 store strobe", {31'd0, s_we}, 32'd1);
        chk("R2 store no rsp", {31'd0, s_rv}, 32'd0);
        do_op(3'd1, 8'h10, 32'd0, 1'b0);
        chk("R3 load data", s_rd, 32'hA5A5_0010);
        chk("R2 load rsp", {31'd0, s_rv}, 32'd1);
        do_op(3'd3, 8'h10, 32'd0, 1'b0);
        chk("R3 ldx data", s_rd, 32'hA5A5_0010);
        do_op(3'd4, 8'h10, 32'h5A5A_0010, 1'b0);
        chk("R5 stx strobe", {31'd0, s_we}, 32'd1);
        chk("R5 stx pass", {31'd0, s_fl}, 32'd0);
        chk("R2 stx rsp", {31'd0, s_rv}, 32'd1);
        do_op(3'd1, 8'h10, 32'd0, 1'b0);
        chk("R5 stx wrote", s_rd, 32'h5A5A_0010);
    endtask

    task automatic t_mismatch;
        do_op(3'd2, 8'h12, 32'h0000_0012, 1'b0);
        do_op(3'd3, 8'h10, 32'd0, 1'b0);
        do_op(3'd4, 8'h12, 32'hDEAD_0012, 1'b0);
        chk("R7 mismatch fail", {31'd0, s_fl}, 32'd1);
        chk("R7 mismatch no we", {31'd0, s_we}, 32'd0);
        do_op(3'd4, 8'h10, 32'hDEAD_0010, 1'b0);
        chk("R8 failed stx dropped resv", {31'd0, s_fl}, 32'd1);
        do_op(3'd1, 8'h12, 32'd0, 1'b0);
        chk("R7 memory unchanged", s_rd, 32'h0000_0012);
    endtask

    task automatic t_twice;
        do_op(3'd3, 8'h30, 32'd0, 1'b0);
        do_op(3'd4, 8'h30, 32'h3030_0001, 1'b0);
        chk("R5 first stx pass", {31'd0, s_fl}, 32'd0);
        do_op(3'd4, 8'h30, 32'h3030_0002, 1'b0);
        chk("R8 second stx fail", {31'd0, s_fl}, 32'd1);
        do_op(3'd1, 8'h30, 32'd0, 1'b0);
        chk("R8 second stx no write", s_rd, 32'h3030_0001);
    endtask

    task automatic t_clear;
        do_op(3'd3, 8'h40, 32'd0, 1'b0);
        do_op(3'd5, 8'h40, 32'd0, 1'b0);
        chk("R2 clear no rsp", {31'd0, s_rv}, 32'd0);
        do_op(3'd4, 8'h40, 32'h4040_0001, 1'b0);
        chk("R9 stx after clear fail", {31'd0, s_fl}, 32'd1);
    endtask

    task automatic t_exception;
        do_op(3'd3, 8'h50, 32'd0, 1'b0);
        do_op(3'd0, 8'h00, 32'd0, 1'b1);
        do_op(3'd4, 8'h50, 32'h5050_0001, 1'b0);
        chk("R10 stx after exception fail", {31'd0, s_fl}, 32'd1);
        do_op(3'd3, 8'h50, 32'd0, 1'b0);
        do_op(3'd4, 8'h50, 32'h5050_0002, 1'b1);
        chk("R10 concurrent exc no we", {31'd0, s_we}, 32'd0);
        chk("R10 concurrent exc fail", {31'd0, s_fl}, 32'd1);
        do_op(3'd2, 8'h52, 32'h5252_0000, 1'b0);
        do_op(3'd3, 8'h52, 32'd0, 1'b1);
        chk("R10 ldx with exc data", s_rd, 32'h5252_0000);
        do_op(3'd4, 8'h52, 32'h5252_0001, 1'b0);
        chk("R10 ldx with exc leaves no resv", {31'd0, s_fl}, 32'd1);
    endtask

    task automatic t_replace;
        do_op(3'd3, 8'h60, 32'd0, 1'b0);
        do_op(3'd3, 8'h61, 32'd0, 1'b0);
        do_op(3'd4, 8'h60, 32'h6060_0001, 1'b0);
        chk("R11 old tag fails", {31'd0, s_fl}, 32'd1);
        do_op(3'd3, 8'h60, 32'd0, 1'b0);
        do_op(3'd3, 8'h61, 32'd0, 1'b0);
        do_op(3'd4, 8'h61, 32'h6161_0001, 1'b0);
        chk("R11 new tag passes", {31'd0, s_fl}, 32'd0);
    endtask

    task automatic t_plain_traffic;
        do_op(3'd3, 8'h70, 32'd0, 1'b0);
        do_op(3'd1, 8'h70, 32'd0, 1'b0);
        do_op(3'd2, 8'h70, 32'h7070_0001, 1'b0);
        do_op(3'd7, 8'h71, 32'd0, 1'b0);
        chk("R2 code 7 no rsp", {31'd0, s_rv}, 32'd0);
        do_op(3'd4, 8'h70, 32'h7070_0002, 1'b0);
        chk("R11 plain traffic keeps resv", {31'd0, s_fl}, 32'd0);
        do_op(3'd1, 8'h70, 32'd0, 1'b0);
        chk("R11 final value", s_rd, 32'h7070_0002);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mismatch();
        t_twice();
        t_clear();
        t_exception();
        t_replace();
        t_plain_traffic();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule